// File: doc/BRIEF.md
# Time-Shared Stereo Serial Audio Port

This block is the serial side of an audio processor. It is the bit-clock master: from the system clock it makes a bit clock and a word-select line. It carries two input channels and two output channels over one serial input line and one serial output line. Each frame has two slots. Channel 1 uses the first slot and channel 2 the second, and all data moves MSB first.

Each slot lasts either 32 or 24 bit clocks. Each of the four channels picks its own word format: a full 32-bit word, a pair of 16-bit halves, a 24-bit word or a 16-bit word. A word shorter than its slot sits at the front of the slot. Toward the processor, the port takes one parallel word per output channel when that channel's slot begins. It returns each received word as a 32-bit value, marked by a single-cycle strobe at the end of the slot.

The settings are plain input pins. They are read at each frame boundary, so changing them mid-frame never disturbs the frame in progress.

Top module: `sap_port`

## Requirements
- R1: After reset, `sck` is 1, `ws` is 0, `sdo` is 0 and `rx_valid` is 0. `sck` then changes level every `HALF_DIV` system clocks, and its first change is a fall.
- R2: A frame is slot 1 followed by slot 2. Slot i lasts 24 bit clocks when `cfg_short_slot[i-1]` is 1 and 32 bit clocks when it is 0.
- R3: `ws` is 0 during channel 1 bit clocks and 1 during channel 2 bit clocks. On the last bit clock of each slot it already carries the next slot's value. It changes only when `sck` falls.
- R4: `sdo` changes only when `sck` falls and sends words MSB first. The 2-bit format codes are 0 for 32-bit, 1 for paired 16-bit, 2 for 24-bit and 3 for 16-bit. Code 0 in a 32-clock slot sends bits 31..0, code 2 sends bits 23..0 and code 3 sends bits 15..0.
- R5: Bit clocks of a slot beyond the word length carry 0 on `sdo`.
- R6: In paired 16-bit format, bits 31..16 go first and bits 15..0 follow. On receive, the first 16 bits fill result bits 31..16 and the next ones fill bits 15..0. In a 24-clock slot only the first 24 bits are carried, and result bits 7..0 read 0.
- R7: Format code 0 in a 24-clock slot behaves as format code 2, both on send and on receive.
- R8: `sdi` is sampled when `sck` rises. Received 24-bit and 16-bit words are right-aligned and sign-extended to 32 bits. A 32-bit word is returned unchanged. Bits past the word length are ignored.
- R9: `rx_valid` is high for exactly one system clock, on the cycle `sck` rises for the last bit clock of a slot. At that time `rx_chan` gives the slot (0 for channel 1, 1 for channel 2) and `rx_data` gives the word.
- R10: The slot-length and format pins are captured once per frame, at its first bit clock. `tx_ch1` is captured at the start of slot 1 and `tx_ch2` at the start of slot 2. Changes at other times affect only later captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_short_slot | input | 2 | Per slot: 1 selects 24 bit clocks, 0 selects 32 |
| cfg_rx_fmt | input | 4 | Receive format codes, bits 1..0 channel 1, bits 3..2 channel 2 |
| cfg_tx_fmt | input | 4 | Transmit format codes, bits 1..0 channel 1, bits 3..2 channel 2 |
| tx_ch1 | input | 32 | Output word for channel 1 |
| tx_ch2 | input | 32 | Output word for channel 2 |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdo | output | 1 | Serial data out |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_chan | output | 1 | Channel of the received word |
| rx_data | output | 32 | Received word, sign-extended or aligned as set by format |

## Verification
The bench builds the port with `HALF_DIV` set to 2, so one bit clock lasts four system clocks and a full frame takes at most 256 cycles. That makes 128 frames affordable. They walk every pairing of the two slot lengths with all four receive formats and all four transmit formats on both channels, including the rejected 32-bit-in-24 case and paired halves cut short by a 24-clock slot. Every pin setting is changed in the middle of each frame, so the frame-boundary capture is exercised on every frame.

// File: rtl/sap_pkg.sv
// Package: shared types and pure functions for the serial audio port.
// Assumes a 32-bit parallel word and two time-shared slots per frame.
package sap_pkg;

    localparam int WORD_W = 32;
    localparam int N_SLOT = 2;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int LONG_LEN  = 32;
    localparam int SHORT_LEN = 24;

    typedef enum logic [1:0] {
        FMT_W32    = 2'd0,
        FMT_PAIR16 = 2'd1,
        FMT_W24    = 2'd2,
        FMT_W16    = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [N_SLOT-1:0]      short_slot;
        logic [N_SLOT-1:0][1:0] rx_fmt;
        logic [N_SLOT-1:0][1:0] tx_fmt;
    } port_cfg_t;

    // Resolve a format code against the slot length; 32-bit cannot fit 24 clocks.
    function automatic fmt_e eff_fmt(input logic [1:0] code, input logic short_slot);
        if (code == FMT_W32 && short_slot) return FMT_W24;
        return fmt_e'(code);
    endfunction

    // Index of the final bit clock in a slot.
    function automatic logic [POS_W-1:0] last_pos(input logic short_slot);
        return short_slot ? POS_W'(SHORT_LEN - 1) : POS_W'(LONG_LEN - 1);
    endfunction

    // Number of bit clocks that carry data for a resolved format.
    function automatic logic [POS_W:0] word_bits(input fmt_e f, input logic short_slot);
        case (f)
            FMT_W32:    return (POS_W+1)'(LONG_LEN);
            FMT_PAIR16: return short_slot ? (POS_W+1)'(SHORT_LEN) : (POS_W+1)'(LONG_LEN);
            FMT_W24:    return (POS_W+1)'(24);
            default:    return (POS_W+1)'(16);
        endcase
    endfunction

    // Move the word so its first transmitted bit sits at bit WORD_W-1.
    function automatic logic [WORD_W-1:0] tx_align(input logic [WORD_W-1:0] w, input fmt_e f);
        case (f)
            FMT_W24: return w << (WORD_W - 24);
            FMT_W16: return w << (WORD_W - 16);
            default: return w;
        endcase
    endfunction

    // Turn the raw right-aligned shift contents into the presented word.
    function automatic logic [WORD_W-1:0] rx_finish(input logic [WORD_W-1:0] raw,
                                                    input fmt_e f, input logic short_slot);
        case (f)
            FMT_W32:    return raw;
            FMT_PAIR16: return short_slot ? (raw << (LONG_LEN - SHORT_LEN)) : raw;
            FMT_W24:    return {{(WORD_W-24){raw[23]}}, raw[23:0]};
            default:    return {{(WORD_W-16){raw[15]}}, raw[15:0]};
        endcase
    endfunction

endpackage

// File: rtl/sap_clkgen.sv
// Bit clock generator: divides the system clock so sck holds each level for
// HALF_DIV system clocks. Emits single-cycle fall/rise event pulses that are
// high on the system clock edge at which sck changes. sck resets high so the
// first change is a fall.
module sap_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sck,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             edge_now;

    // An sck change is due when the half-period counter reaches its top.
    always_comb begin
        edge_now = (cnt_q == CNT_TOP);
        fall_ev  = edge_now & sck;
        rise_ev  = edge_now & ~sck;
    end

    // Advance the half-period counter and flip sck at its top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck   <= 1'b1;
        end else if (edge_now) begin
            cnt_q <= '0;
            sck   <= ~sck;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sap_sequencer.sv
// Frame sequencer: tracks slot and bit position, drives word select, and
// captures the configuration at each frame boundary. Positions advance on
// sck falls. cfg_now exposes the setting that applies to the bit being
// entered, so consumers loading at a frame start see the new frame's setting.
module sap_sequencer
    import sap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_ev,
    input  port_cfg_t        cfg_in,
    output port_cfg_t        cfg_q,
    output logic             slot_q,
    output logic [POS_W-1:0] pos_q,
    output logic             ws,
    output logic             load_ev,
    output logic             load_slot,
    output fmt_e             load_fmt
);
    logic             started_q;
    logic             wrap;
    port_cfg_t        cfg_now;
    logic             slot_n;
    logic [POS_W-1:0] pos_n;
    logic             ws_n;

    // Work out the next bit position and the word-select level that goes with it.
    always_comb begin
        wrap    = !started_q || (slot_q && pos_q == last_pos(cfg_q.short_slot[1]));
        cfg_now = wrap ? cfg_in : cfg_q;
        if (wrap) begin
            slot_n = 1'b0;
            pos_n  = '0;
        end else if (pos_q == last_pos(cfg_q.short_slot[slot_q])) begin
            slot_n = ~slot_q;
            pos_n  = '0;
        end else begin
            slot_n = slot_q;
            pos_n  = pos_q + 1'b1;
        end
        ws_n = (pos_n == last_pos(cfg_now.short_slot[slot_n])) ? ~slot_n : slot_n;
    end

    // Tell the transmit side when a slot begins and which resolved format it uses.
    always_comb begin
        load_ev   = fall_ev && (pos_n == '0);
        load_slot = slot_n;
        load_fmt  = eff_fmt(cfg_now.tx_fmt[slot_n], cfg_now.short_slot[slot_n]);
    end

    // Register position, word select and per-frame configuration on each sck fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            slot_q    <= 1'b1;
            pos_q     <= '0;
            ws        <= 1'b0;
            cfg_q     <= '0;
        end else if (fall_ev) begin
            started_q <= 1'b1;
            slot_q    <= slot_n;
            pos_q     <= pos_n;
            ws        <= ws_n;
            if (wrap) cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/sap_tx_shift.sv
// Transmit shifter: at a slot start it captures that slot's word, aligns it
// so the first bit is at the top, and then presents one bit per sck fall.
// Zeros enter from the bottom, so the bits after a short word are zero.
module sap_tx_shift
    import sap_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_ev,
    input  logic                          load_ev,
    input  logic                          load_slot,
    input  fmt_e                          load_fmt,
    input  logic [N_SLOT-1:0][WORD_W-1:0] words,
    output logic                          sdo
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] aligned;

    // Align the word for the slot about to start.
    always_comb aligned = tx_align(words[load_slot], load_fmt);

    // Load at slot start, otherwise shift out the next bit on each sck fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            sdo  <= 1'b0;
        end else if (load_ev) begin
            sdo  <= aligned[WORD_W-1];
            sh_q <= aligned << 1;
        end else if (shift_ev) begin
            sdo  <= sh_q[WORD_W-1];
            sh_q <= sh_q << 1;
        end
    end
endmodule

// File: rtl/sap_rx_shift.sv
// Receive shifter: samples sdi on sck rises while the slot's word is still
// arriving, restarts at bit 0 of each slot, and at the last bit of the slot
// presents the finished word with a one-cycle strobe.
module sap_rx_shift
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_ev,
    input  logic              slot_q,
    input  logic [POS_W-1:0]  pos_q,
    input  fmt_e              fmt,
    input  logic              short_slot,
    input  logic              sdi,
    output logic              rx_valid,
    output logic              rx_chan,
    output logic [WORD_W-1:0] rx_data
);
    logic [WORD_W-1:0] raw_q;
    logic [WORD_W-1:0] raw_n;
    logic              take;
    logic              is_last;

    // Include the current bit only while it belongs to the word.
    always_comb begin
        take    = {1'b0, pos_q} < word_bits(fmt, short_slot);
        is_last = (pos_q == last_pos(short_slot));
        if (!take)               raw_n = raw_q;
        else if (pos_q == '0)    raw_n = {{(WORD_W-1){1'b0}}, sdi};
        else                     raw_n = {raw_q[WORD_W-2:0], sdi};
    end

    // Accumulate on sck rises and publish the word at the last bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q    <= '0;
            rx_valid <= 1'b0;
            rx_chan  <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sample_ev) begin
                raw_q <= raw_n;
                if (is_last) begin
                    rx_valid <= 1'b1;
                    rx_chan  <= slot_q;
                    rx_data  <= rx_finish(raw_n, fmt, short_slot);
                end
            end
        end
    end
endmodule

// File: rtl/sap_port.sv
// Top level of the time-shared stereo serial audio port. It acts as bit-clock
// master and joins the clock generator, the frame sequencer and the two
// shifters. Assumes sdi is set up by the far end after sck falls.
module sap_port
    import sap_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_short_slot,
    input  logic [3:0]  cfg_rx_fmt,
    input  logic [3:0]  cfg_tx_fmt,
    input  logic [31:0] tx_ch1,
    input  logic [31:0] tx_ch2,
    input  logic        sdi,
    output logic        sck,
    output logic        ws,
    output logic        sdo,
    output logic        rx_valid,
    output logic        rx_chan,
    output logic [31:0] rx_data
);
    logic                          fall_ev;
    logic                          rise_ev;
    port_cfg_t                     cfg_in;
    port_cfg_t                     cfg_q;
    logic                          slot_q;
    logic [POS_W-1:0]              pos_q;
    logic                          load_ev;
    logic                          load_slot;
    fmt_e                          load_fmt;
    logic [N_SLOT-1:0][WORD_W-1:0] tx_words;
    fmt_e                          rx_mode [N_SLOT];

    // Gather the pins into the configuration record and the word bank.
    always_comb begin
        cfg_in.short_slot = cfg_short_slot;
        cfg_in.rx_fmt     = cfg_rx_fmt;
        cfg_in.tx_fmt     = cfg_tx_fmt;
        tx_words[0]       = tx_ch1;
        tx_words[1]       = tx_ch2;
    end

    // Resolve the per-channel receive format against its slot length.
    for (genvar ch = 0; ch < N_SLOT; ch++) begin : g_rx_mode
        assign rx_mode[ch] = eff_fmt(cfg_q.rx_fmt[ch], cfg_q.short_slot[ch]);
    end

    sap_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    sap_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_ev   (fall_ev),
        .cfg_in    (cfg_in),
        .cfg_q     (cfg_q),
        .slot_q    (slot_q),
        .pos_q     (pos_q),
        .ws        (ws),
        .load_ev   (load_ev),
        .load_slot (load_slot),
        .load_fmt  (load_fmt)
    );

    sap_tx_shift u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_ev  (fall_ev),
        .load_ev   (load_ev),
        .load_slot (load_slot),
        .load_fmt  (load_fmt),
        .words     (tx_words),
        .sdo       (sdo)
    );

    sap_rx_shift u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_ev  (rise_ev),
        .slot_q     (slot_q),
        .pos_q      (pos_q),
        .fmt        (rx_mode[slot_q]),
        .short_slot (cfg_q.short_slot[slot_q]),
        .sdi        (sdi),
        .rx_valid   (rx_valid),
        .rx_chan    (rx_chan),
        .rx_data    (rx_data)
    );
endmodule

// File: rtl/sap_port_chk.sv
// Checker for sap_port: watches only the top-level pins and relates their
// timing to one another. It is attached to every sap_port instance by bind.
module sap_port_chk #(
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic ws,
    input logic sdo,
    input logic rx_valid,
    input logic rx_chan
);
    int phase_q;

    // Count system clocks within each half bit period, starting from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        phase_q <= 0;
        else if (phase_q == HALF_DIV - 1)  phase_q <= 0;
        else                               phase_q <= phase_q + 1;
    end

    // R1
    sck_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |-> ($past(phase_q) == HALF_DIV - 1));

    // R4
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $fell(sck));

    // R3
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> $fell(sck));

    // R9
    valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(sck));

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3
    chan_vs_ws_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_chan != ws));
endmodule

bind sap_port sap_port_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .ws       (ws),
    .sdo      (sdo),
    .rx_valid (rx_valid),
    .rx_chan  (rx_chan)
);

// File: tb/sap_port_test.sv
// Bench for sap_port: plays the far-end codec over 128 frames, sweeping slot
// lengths and every format on both channels, with expectations computed
// arithmetically from the requirements.
module sap_port_test;
    localparam int HALF_DIV = 2;
    localparam int NF       = 128;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_short_slot;
    logic [3:0]  cfg_rx_fmt;
    logic [3:0]  cfg_tx_fmt;
    logic [31:0] tx_ch1;
    logic [31:0] tx_ch2;
    logic        sdi = 1'b0;
    logic        sck, ws, sdo, rx_valid, rx_chan;
    logic [31:0] rx_data;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    sap_port #(.HALF_DIV(HALF_DIV)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_short_slot (cfg_short_slot),
        .cfg_rx_fmt     (cfg_rx_fmt),
        .cfg_tx_fmt     (cfg_tx_fmt),
        .tx_ch1         (tx_ch1),
        .tx_ch2         (tx_ch2),
        .sdi            (sdi),
        .sck            (sck),
        .ws             (ws),
        .sdo            (sdo),
        .rx_valid       (rx_valid),
        .rx_chan        (rx_chan),
        .rx_data        (rx_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Pin settings for frame i.
    task automatic apply_pins(input int i);
        logic [6:0] b;
        b = 7'(i);
        cfg_short_slot = b[1:0];
        cfg_rx_fmt     = {b[5:4], b[3:2]};
        cfg_tx_fmt     = {b[3:2] ^ {b[6], b[6]}, b[5:4]};
        tx_ch1         = (32'h9E3779B9 * 32'(2*i + 1)) ^ {32{b[0]}};
        tx_ch2         = 32'h7F4A7C15 * 32'(3*i + 5);
    endtask

    function automatic logic [31:0] rx_pat(input int i, input int s);
        return 32'hC2B2AE35 * 32'(4*i + s + 1);
    endfunction

    function automatic int slot_len(input logic short_slot);
        return short_slot ? 24 : 32;
    endfunction

    function automatic logic exp_tx_bit(input logic [31:0] w, input logic [1:0] code,
                                        input logic short_slot, input int p);
        if (code == 2'd1 || (code == 2'd0 && !short_slot)) return w[31-p];
        if (code == 2'd3) return (p < 16) ? w[15-p] : 1'b0;
        return (p < 24) ? w[23-p] : 1'b0;
    endfunction

    function automatic int tx_len(input logic [1:0] code, input logic short_slot);
        if (code == 2'd1) return slot_len(short_slot);
        if (code == 2'd0 && !short_slot) return 32;
        if (code == 2'd3) return 16;
        return 24;
    endfunction

    function automatic logic [31:0] exp_rx(input logic [31:0] pat, input logic [1:0] code,
                                           input logic short_slot);
        if (code == 2'd0 && !short_slot) return pat;
        if (code == 2'd1) return short_slot ? {pat[31:8], 8'h00} : pat;
        if (code == 2'd3) return {{16{pat[31]}}, pat[31:16]};
        return {{8{pat[31]}}, pat[31:8]};
    endfunction

    function automatic string fmt_tag(input logic [1:0] code, input logic short_slot);
        if (code == 2'd0 && short_slot) return "R7";
        if (code == 2'd1) return "R6";
        return "R8";
    endfunction

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        logic [1:0]  cur_short;
        logic [3:0]  cur_rx, cur_tx;
        logic [31:0] cur_word [2];
        logic [31:0] pat;
        logic        prev_sck;
        logic        exp_ws, exp_bit;
        logic [1:0]  code;
        int          elapsed, s, p, frame;
        bit          started, done, is_last;
        string       tag;

        apply_pins(0);
        cur_short = '0; cur_rx = '0; cur_tx = '0;
        cur_word[0] = '0; cur_word[1] = '0;
        pat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(sck == 1'b1, "R1 sck reset", 32'(sck), 32'd1);
        check(ws == 1'b0, "R1 ws reset", 32'(ws), 32'd0);
        check(sdo == 1'b0, "R1 sdo reset", 32'(sdo), 32'd0);
        check(rx_valid == 1'b0, "R1 rx_valid reset", 32'(rx_valid), 32'd0);
        rst_n = 1'b1;

        prev_sck = 1'b1; elapsed = 0; started = 0; done = 0;
        s = 1; p = 0; frame = -1;
        while (!done) begin
            @(negedge clk);
            elapsed++;
            if (sck != prev_sck) begin
                check(elapsed == HALF_DIV, "R1 sck half period", 32'(elapsed), 32'(HALF_DIV));
                elapsed = 0;
                if (!sck) begin
                    if (!started || (s == 1 && p == slot_len(cur_short[1]) - 1)) begin
                        started = 1; s = 0; p = 0; frame++;
                        if (frame == NF) begin
                            done = 1;
                        end else begin
                            // R10: settings for this frame are the pins at its first bit;
                            // they are changed at once for the next frame.
                            cur_short   = cfg_short_slot;
                            cur_rx      = cfg_rx_fmt;
                            cur_tx      = cfg_tx_fmt;
                            cur_word[0] = tx_ch1;
                            apply_pins(frame + 1);
                        end
                    end else if (p == slot_len(cur_short[s]) - 1) begin
                        s = 1; p = 0;
                        cur_word[1] = tx_ch2;
                    end else begin
                        p++;
                    end
                    if (!done) begin
                        exp_ws = (p == slot_len(cur_short[s]) - 1) ? ~s[0] : s[0];
                        check(ws == exp_ws, "R3 ws", 32'(ws), 32'(exp_ws));
                        code    = (s == 0) ? cur_tx[1:0] : cur_tx[3:2];
                        exp_bit = exp_tx_bit(cur_word[s], code, cur_short[s], p);
                        if (p >= tx_len(code, cur_short[s]))      tag = "R5/R10 sdo";
                        else if (code == 2'd0 && cur_short[s])   tag = "R7/R10 sdo";
                        else if (code == 2'd1)                   tag = "R6/R10 sdo";
                        else                                     tag = "R4/R10 sdo";
                        check(sdo == exp_bit, tag, 32'(sdo), 32'(exp_bit));
                        if (p == 0) pat = rx_pat(frame, s);
                        sdi = pat[31-p];
                    end
                end else begin
                    is_last = (p == slot_len(cur_short[s]) - 1);
                    check(rx_valid == is_last, "R2/R9 rx_valid at slot end", 32'(rx_valid), 32'(is_last));
                    if (rx_valid && is_last) begin
                        check(rx_chan == s[0], "R9 rx_chan", 32'(rx_chan), 32'(s));
                        code = (s == 0) ? cur_rx[1:0] : cur_rx[3:2];
                        check(rx_data == exp_rx(pat, code, cur_short[s]),
                              {fmt_tag(code, cur_short[s]), " rx_data"},
                              rx_data, exp_rx(pat, code, cur_short[s]));
                    end
                end
                prev_sck = sck;
            end else begin
                check(rx_valid == 1'b0, "R9 rx_valid single cycle", 32'(rx_valid), 32'd0);
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule